// File: doc/BRIEF.md
# Elapsed-Time Counter with Compare

This block keeps a free-running 48-bit binary count that steps once per cycle in which `tick_en` is high. The tick enable is meant to pulse at 32.768 kHz. That makes the low 16-bit word wrap every two seconds, and the upper 32 bits count whole two-second periods. A host reaches the count through a small 16-bit register port. The count is split into low, middle and high words. Reads are made coherent by a shadow capture, and writes are applied atomically.

A second 48-bit value, written as three 16-bit words, is compared with the count. On the tick that brings the count equal to the compare value, a sticky status bit is raised and driven out as an interrupt level. Writing a one to that bit clears it. A compare value of zero in all three words disarms the match.

Register map (`bus_addr`): 0 = count low, 1 = count middle, 2 = count high, 3 = status (bit 0 is the match flag), 4 = compare low, 5 = compare middle, 6 = compare high. Address 7 is unmapped.

Top module: `elapsed_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the compare value, the write staging and read shadow registers, and the status bit are all cleared; after reset every mapped address reads 0 and `match_irq` is 0.
- R2: In a cycle with `tick_en` high and no write to address 0, the 48-bit count increases by exactly one; with `tick_en` low and no such write it holds.
- R3: The count is one binary value: a tick at low word 0xFFFF carries into the middle word, and a tick at 0xFFFF_FFFF_FFFF wraps the whole count to zero.
- R4: Writes to address 1 or 2 only stage a word and leave the count unchanged; a write to address 0 loads the count with {staged high, staged middle, written low} in one edge.
- R5: When a write to address 0 and a tick fall in the same cycle, the written value is loaded and that tick is dropped.
- R6: A read of address 2 returns the live high word and, at that edge, captures the live middle and low words; reads of addresses 1 and 0 return the captured words until the next read of address 2.
- R7: Writes to addresses 4, 5 and 6 take effect at once, and the words read back unchanged from the same addresses.
- R8: On a tick (with no write to address 0) that brings the count equal to a non-zero compare value, the status bit is set on that edge and stays set while ticks continue.
- R9: With the compare value all zero, the status bit is never set, including when the count wraps to zero.
- R10: Writing address 3 with bit 0 = 1 clears the status bit; bit 0 = 0 leaves it alone; a match in the same cycle as the clear leaves it set.
- R11: `match_irq` always equals the status bit, which reads back as bit 0 of address 3 with the upper bits zero.
- R12: Address 7 reads as zero, and a write to it changes no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle count enable, nominally 32.768 kHz |
| bus_rd | input | 1 | Host read strobe for `bus_addr` |
| bus_wr | input | 1 | Host write strobe for `bus_addr` |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| match_irq | output | 1 | Level interrupt, equal to the status bit |

## Verification
The bench builds the block with its default 16-bit word, so the count has its full 48-bit width. Because the count can be written, directed tests place it just below the low-word carry and just below the full 48-bit wrap, so both edges are reached in a few ticks. Random traffic then keeps the compare low word a few ticks ahead of the count while the upper compare words match it. This makes matches, set-versus-clear collisions and write-versus-tick collisions frequent, and a reference model in the bench checks every read and the interrupt level on every cycle.

// File: rtl/et_pkg.sv
// Shared constants for the elapsed-time counter: address map and word count.
// Assumes a fixed layout of three words per 48-bit value.
package et_pkg;
    localparam int NUM_WORDS = 3;
    localparam int IDX_W     = 2;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_MID = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP_MID = 3'd5;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 3'd6;
endpackage

// File: rtl/et_count.sv
// Elapsed-time counter with staged host load.
// Upper words are staged on write; a write of word 0 loads all words at once
// and takes priority over a tick in the same cycle.
// Assumes wr_idx is one of 0..NUM_WORDS-1 whenever wr_en is high.
module et_count
    import et_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] load_val;
    logic             commit;

    assign commit = wr_en && (wr_idx == '0);
    assign load_val[0 +: WORD_W] = wdata;

    for (genvar i = 1; i < NUM_WORDS; i++) begin : g_stage
        logic [WORD_W-1:0] stage_q;
        // Hold the host's pending upper word until the low word commits
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                stage_q <= wdata;
        end
        assign load_val[i*WORD_W +: WORD_W] = stage_q;
    end

    // Advance on tick, or load the assembled host value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (commit)
            cnt <= load_val;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/et_compare.sv
// Compare value storage and sticky match status.
// Matches against the value the count takes on this tick; an all-zero compare
// value disarms the match. A new match wins over a clear in the same cycle.
module et_compare
    import et_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tick,
    input  logic              commit,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              clr,
    output logic [CNT_W-1:0]  cmp,
    output logic              status
);
    logic hit;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_cmp
        // Store one compare word straight from the host
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp[i*WORD_W +: WORD_W] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                cmp[i*WORD_W +: WORD_W] <= wdata;
        end
    end

    assign hit = tick && !commit && (|cmp) && ((cnt + CNT_W'(1)) == cmp);

    // Sticky match flag, write-one-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (hit)
            status <= 1'b1;
        else if (clr)
            status <= 1'b0;
    end
endmodule

// File: rtl/et_hostif.sv
// Host register decode, read multiplexer and coherent-read shadow.
// Reading the high count word captures the middle and low words; later reads
// of those addresses return the captured copy. Read data is combinational.
module et_hostif
    import et_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              status,
    output logic              cnt_wr,
    output logic              cmp_wr,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              stat_clr,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [WORD_W-1:0] sh_lo;
    logic [WORD_W-1:0] sh_mid;
    logic              word_slot;

    assign wr_idx    = bus_addr[IDX_W-1:0];
    assign word_slot = (wr_idx != IDX_W'(NUM_WORDS));
    assign cnt_wr    = bus_wr && !bus_addr[ADDR_W-1] && word_slot;
    assign cmp_wr    = bus_wr &&  bus_addr[ADDR_W-1] && word_slot;
    assign stat_clr  = bus_wr && (bus_addr == A_STATUS) && bus_wdata[0];

    // Capture the lower words when the host reads the high word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lo  <= '0;
            sh_mid <= '0;
        end else if (bus_rd && (bus_addr == A_CNT_HI)) begin
            sh_lo  <= cnt[0 +: WORD_W];
            sh_mid <= cnt[WORD_W +: WORD_W];
        end
    end

    // Select the addressed register for the host
    always_comb begin
        case (bus_addr)
            A_CNT_LO:  bus_rdata = sh_lo;
            A_CNT_MID: bus_rdata = sh_mid;
            A_CNT_HI:  bus_rdata = cnt[2*WORD_W +: WORD_W];
            A_STATUS:  bus_rdata = {{(WORD_W-1){1'b0}}, status};
            A_CMP_LO:  bus_rdata = cmp[0 +: WORD_W];
            A_CMP_MID: bus_rdata = cmp[WORD_W +: WORD_W];
            A_CMP_HI:  bus_rdata = cmp[2*WORD_W +: WORD_W];
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/elapsed_timer.sv
// Top level: 48-bit elapsed-time counter with a compare interrupt.
// Ties host decode, counter and compare together; match_irq is the status bit.
// Assumes tick_en is a single-cycle pulse synchronous to clk.
module elapsed_timer
    import et_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              match_irq
);
    localparam int CNT_W = WORD_W * NUM_WORDS;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             stat_q;
    logic             cnt_wr;
    logic             cmp_wr;
    logic             stat_clr;
    logic [IDX_W-1:0] wr_idx;
    logic             commit;

    assign commit    = cnt_wr && (wr_idx == '0);
    assign match_irq = stat_q;

    et_hostif #(.WORD_W(WORD_W)) u_hostif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt_q),
        .cmp       (cmp_q),
        .status    (stat_q),
        .cnt_wr    (cnt_wr),
        .cmp_wr    (cmp_wr),
        .wr_idx    (wr_idx),
        .stat_clr  (stat_clr),
        .bus_rdata (bus_rdata)
    );

    et_count #(.WORD_W(WORD_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .wr_en  (cnt_wr),
        .wr_idx (wr_idx),
        .wdata  (bus_wdata),
        .cnt    (cnt_q)
    );

    et_compare #(.WORD_W(WORD_W)) u_compare (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmp_wr),
        .wr_idx (wr_idx),
        .wdata  (bus_wdata),
        .tick   (tick_en),
        .commit (commit),
        .cnt    (cnt_q),
        .clr    (stat_clr),
        .cmp    (cmp_q),
        .status (stat_q)
    );
endmodule

// File: rtl/et_checker.sv
// Protocol checker for elapsed_timer, bound to every instance of it.
// Observes the top ports plus the count, compare and status registers.
module et_checker
    import et_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = WORD_W * NUM_WORDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              status,
    input logic              match_irq
);
    logic load_lo;
    logic clr_req;

    assign load_lo = bus_wr && (bus_addr == A_CNT_LO);
    assign clr_req = bus_wr && (bus_addr == A_STATUS) && bus_wdata[0];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && cmp == '0 && !status && !match_irq)); // R1

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_lo) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_lo) |=> $stable(cnt)); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (cnt[0 +: WORD_W] == $past(bus_wdata))); // R5

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_lo && (|cmp) && (cnt + CNT_W'(1) == cmp)) |=> status); // R8

    AST_ZERO_CMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0 && !status) |=> !status); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_req) |=> status); // R10
endmodule

bind elapsed_timer et_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .cmp       (cmp_q),
    .status    (stat_q),
    .match_irq (match_irq)
);

// File: tb/tb_elapsed_timer.sv
// Self-checking bench: reference model updated per cycle, directed corners
// followed by seeded random traffic.
module tb_elapsed_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        match_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [47:0] m_cnt, m_cmp;
    logic [15:0] m_stg_mid, m_stg_hi, m_sh_lo, m_sh_mid;
    bit          m_stat;

    elapsed_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .match_irq(match_irq)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_sh_lo;
            3'd1: return m_sh_mid;
            3'd2: return m_cnt[47:32];
            3'd3: return {15'b0, m_stat};
            3'd4: return m_cmp[15:0];
            3'd5: return m_cmp[31:16];
            3'd6: return m_cmp[47:32];
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_cmp = '0; m_stg_mid = '0; m_stg_hi = '0;
        m_sh_lo = '0; m_sh_mid = '0; m_stat = 0;
    endtask

    // one clock: check irq, drive, check read data, then advance the model
    task automatic cycle(input string req, input bit tk, input bit wr, input bit rd,
                         input logic [2:0] a, input logic [15:0] d);
        bit commit, hit;
        @(negedge clk);
        check("R11 irq", {47'b0, match_irq}, {47'b0, m_stat});
        tick_en = tk; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        if (rd) check(req, {32'b0, bus_rdata}, {32'b0, exp_read(a)});
        @(posedge clk);
        commit = wr && a == 3'd0;
        hit = tk && !commit && m_cmp != 0 && (m_cnt + 48'd1) == m_cmp;
        if (rd && a == 3'd2) begin m_sh_lo = m_cnt[15:0]; m_sh_mid = m_cnt[31:16]; end
        if (commit) m_cnt = {m_stg_hi, m_stg_mid, d};
        else if (tk) m_cnt = m_cnt + 48'd1;
        if (wr && a == 3'd1) m_stg_mid = d;
        if (wr && a == 3'd2) m_stg_hi = d;
        if (wr && a == 3'd4) m_cmp[15:0] = d;
        if (wr && a == 3'd5) m_cmp[31:16] = d;
        if (wr && a == 3'd6) m_cmp[47:32] = d;
        if (hit) m_stat = 1;
        else if (wr && a == 3'd3 && d[0]) m_stat = 0;
        #1 tick_en = 0; bus_wr = 0; bus_rd = 0;
    endtask

    task automatic rd(input string req, input logic [2:0] a);
        cycle(req, 0, 0, 1, a, 16'h0);
    endtask
    task automatic wr(input string req, input logic [2:0] a, input logic [15:0] d);
        cycle(req, 0, 1, 0, a, d);
    endtask
    task automatic ticks(input string req, input int n);
        for (int i = 0; i < n; i++) cycle(req, 1, 0, 0, 3'd0, 16'h0);
    endtask
    // read the full count coherently: high, then middle, then low
    task automatic rd_count(input string req);
        rd(req, 3'd2); rd(req, 3'd1); rd(req, 3'd0);
    endtask
    task automatic load_count(input string req, input logic [47:0] v);
        wr(req, 3'd2, v[47:32]); wr(req, 3'd1, v[31:16]); wr(req, 3'd0, v[15:0]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: everything reads zero after reset
        for (int a = 0; a < 8; a++) rd("R1 reset value", 3'(a));

        // R2: count steps per tick and holds between ticks
        ticks("R2", 5);
        rd_count("R2 after five ticks");
        cycle("R2", 0, 0, 0, 3'd0, 16'h0);
        cycle("R2", 0, 0, 0, 3'd0, 16'h0);
        rd_count("R2 hold without tick");

        // R4: upper writes only stage
        wr("R4", 3'd1, 16'hFFFF);
        wr("R4", 3'd2, 16'hABCD);
        rd_count("R4 staged words do not move count");
        wr("R4", 3'd0, 16'hFFFE);
        rd_count("R4 atomic load");

        // R3: low-to-middle carry, then full wrap
        ticks("R3", 3);
        rd_count("R3 carry out of low and middle word");
        load_count("R3", 48'hFFFF_FFFF_FFFF);
        ticks("R3", 1);
        rd_count("R3 full wrap to zero");

        // R5: write and tick in the same cycle
        wr("R5", 3'd2, 16'h0001); wr("R5", 3'd1, 16'h0002);
        cycle("R5", 1, 1, 0, 3'd0, 16'h0300);
        rd_count("R5 write beats tick");

        // R6: shadow holds across ticks until the next high read
        rd("R6", 3'd2);
        ticks("R6", 7);
        rd("R6 captured middle", 3'd1);
        rd("R6 captured low", 3'd0);
        rd_count("R6 fresh capture");

        // R7 and R12: compare read-back, unmapped address
        wr("R7", 3'd4, 16'h1357); wr("R7", 3'd5, 16'h2468); wr("R7", 3'd6, 16'h9ABC);
        rd("R7 compare low", 3'd4); rd("R7 compare middle", 3'd5); rd("R7 compare high", 3'd6);
        wr("R12", 3'd7, 16'hFFFF);
        for (int a = 0; a < 8; a++) rd("R12 unmapped write left state alone", 3'(a));

        // R8: match sets sticky status
        load_count("R8", 48'h0000_0000_0010);
        wr("R8", 3'd6, 16'h0); wr("R8", 3'd5, 16'h0); wr("R8", 3'd4, 16'h0013);
        ticks("R8 before match", 2);
        rd("R8 no match yet", 3'd3);
        ticks("R8 match tick", 1);
        rd("R8 status set", 3'd3);
        ticks("R8 stays set", 4);
        rd("R8 still set", 3'd3);

        // R10: write zero keeps, write one clears
        wr("R10", 3'd3, 16'hFFFE);
        rd("R10 zero bit has no effect", 3'd3);
        wr("R10", 3'd3, 16'h0001);
        rd("R10 cleared", 3'd3);

        // R10: set beats clear in the same cycle
        load_count("R10", 48'h0000_0000_0012);
        cycle("R10", 1, 1, 0, 3'd3, 16'h0001);
        rd("R10 set wins over clear", 3'd3);
        wr("R10", 3'd3, 16'h0001);

        // R9: zero compare never matches, even across the wrap to zero
        wr("R9", 3'd4, 16'h0);
        load_count("R9", 48'hFFFF_FFFF_FFFD);
        ticks("R9 across wrap", 6);
        rd("R9 no status", 3'd3);
        rd_count("R9 count wrapped");

        // random traffic with matches kept near
        void'($urandom(32'd20240611));
        load_count("R2", 48'h0000_1234_0100);
        wr("R8", 3'd6, 16'h0000); wr("R8", 3'd5, 16'h1234);
        for (int i = 0; i < 4000; i++) begin
            bit tk;
            int op;
            logic [2:0] a;
            tk = 1'($urandom);
            op = int'($urandom % 10);
            a = 3'($urandom);
            if (op < 4)
                cycle("R2 random idle", tk, 0, 0, 3'd0, 16'h0);
            else if (op < 7)
                cycle("R6 random read", tk, 0, 1, a, 16'h0);
            else if (op == 7)
                cycle("R8 random compare", tk, 1, 0, 3'd4, m_cnt[15:0] + 16'($urandom % 6));
            else if (op == 8)
                cycle("R10 random clear", tk, 1, 0, 3'd3, 16'($urandom % 2));
            else
                cycle("R5 random load", tk, 1, 0, 3'd0, m_cnt[15:0] - 16'($urandom % 4));
        end
        rd_count("R2 end of random");
        finish_run();
    end
endmodule